// File: doc/BRIEF.md
# Cascaded BCD Event Counter with Display-Gated Overflow

The block tallies events on a single trigger line into a chain of decimal digits, eight by default, so the readable range runs from 0 to 99999999. A count happens when the trigger line falls. Each digit steps through 0..9 in plain 8-4-2-1 code. When a digit wraps from 9 back to 0 it advances the next digit up. All inputs are sampled on one system clock. The falling edge is found by comparing the trigger with a registered copy of itself. Every digit that the edge ripples through changes at the same clock edge.

When the top digit wraps, the whole counter has rolled past its maximum. A sticky full-count flag records this. The flag does not reach the overflow pin on its own. It is shown there only when the active-low display strobe is sampled low. After that the pin stays asserted. It is released only by a counter reset taken while the strobe is high. A small state machine with four states carries this two-stage path:
- `OV_CLEAR`: flag clear, pin high.
- `OV_PENDING`: flag set, pin high.
- `OV_SHOWN`: flag set, pin low.
- `OV_HELD`: flag cleared by a reset under a low strobe, pin still low.

Its transitions are:
- full-count: CLEAR→PENDING.
- strobe: PENDING→SHOWN.
- reset under high strobe: any state→CLEAR.
- reset under low strobe: SHOWN→HELD, and PENDING→CLEAR.
- full-count: HELD→SHOWN.

Top module: `bcd_event_counter`

## Requirements
- R1: A high-to-low change of `trig_i` adds exactly one to the count. A rising change, or a level held high or low, leaves the count unchanged.
- R2: The count changes at the first clock edge where `trig_i` is sampled low after being sampled high. It is visible on `digits_o` right after that edge.
- R3: A clock edge with `cnt_rst_n` low sets every digit to 0. This holds even when a trigger fall is sampled at the same edge.
- R4: Every digit stays in 0..9. A digit wraps from 9 to 0 and advances the next digit at the same clock edge, so a carry through several digits (099 to 100) completes in one edge.
- R5: Digit k, counted from the least significant digit as k=0, sits at `digits_o[4k+3:4k]` with bit 4k weighted 1. So a count of 123 on three digits reads 12'h123.
- R6: A count from the all-nines value wraps every digit to 0 and sets the internal full-count flag.
- R7: `ovf_n` stays high after a full count until `disp_n` is sampled low while the flag is set. It goes low at that edge.
- R8: Once low, `ovf_n` ignores further counts and strobe changes. It goes high at the first edge with `cnt_rst_n` low and `disp_n` high.
- R9: A reset taken while `disp_n` is low clears the flag but leaves an asserted `ovf_n` low.
- R10: When reset and a low strobe meet a flag that is set but not yet shown, the reset wins. `ovf_n` stays high, and later strobes do not assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| trig_i | input | 1 | Event input; a fall counts one event |
| cnt_rst_n | input | 1 | Active-low counter reset; clears digits and full-count flag |
| disp_n | input | 1 | Active-low display strobe; gates the overflow pin |
| digits_o | output | 4*NUM_DECADES | BCD digits, least significant digit in bits 3:0 |
| ovf_n | output | 1 | Active-low overflow indication |

## Verification
Each input is driven just after a falling clock edge. A count, a reset or a strobe therefore takes effect at the very next rising edge, and both `digits_o` and `ovf_n` show it one clock later. The overflow pin is a strobe delay behind the full count: the full count sets the flag at edge N, and a strobe sampled at edge N+1 or later asserts the pin at that edge. The bench keeps a behavioural model that it updates on each rising edge. It compares the model with the outputs at every falling edge, half a cycle after any change. The bench sets the digit count to three so that rollover is reached in about two thousand cycles.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef enum logic [1:0] {
        OV_CLEAR   = 2'b00,
        OV_PENDING = 2'b01,
        OV_SHOWN   = 2'b10,
        OV_HELD    = 2'b11
    } ovf_state_e;

endpackage

// File: rtl/bcdc_fall_detect.sv
module bcdc_fall_detect (
    input  logic clk,
    input  logic sig_i,
    output logic fall_o
);

    logic sig_q;

    // Sampling register only; it follows the input in every cycle.
    always_ff @(posedge clk) begin
        sig_q <= sig_i;
    end

    assign fall_o = sig_q & ~sig_i;

endmodule

// File: rtl/bcdc_decade.sv
module bcdc_decade
    import bcdc_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n_i,
    input  logic               en_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               carry_o
);

    localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(DIGIT_MAX);

    logic [DIGIT_W-1:0] digit_q;
    logic               at_last;

    assign at_last = (digit_q == LAST);

    always_ff @(posedge clk) begin
        if (!clr_n_i) begin
            digit_q <= '0;
        end else if (en_i) begin
            digit_q <= at_last ? '0 : digit_q + 1'b1;
        end
    end

    // Carry to the next digit at the same edge as the wrap from 9 to 0.
    assign carry_o = en_i & at_last;
    assign digit_o = digit_q;

endmodule

// File: rtl/bcdc_ovf_fsm.sv
module bcdc_ovf_fsm
    import bcdc_pkg::*;
(
    input  logic clk,
    input  logic clr_n_i,
    input  logic full_i,
    input  logic strobe_n_i,
    output logic ovf_n_o
);

    ovf_state_e state_q;
    ovf_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_CLEAR: begin
                if (clr_n_i && full_i) state_d = OV_PENDING;
            end
            OV_PENDING: begin
                if (!clr_n_i)         state_d = OV_CLEAR;
                else if (!strobe_n_i) state_d = OV_SHOWN;
            end
            OV_SHOWN: begin
                if (!clr_n_i) state_d = strobe_n_i ? OV_CLEAR : OV_HELD;
            end
            OV_HELD: begin
                if (!clr_n_i) begin
                    if (strobe_n_i) state_d = OV_CLEAR;
                end else if (full_i) begin
                    state_d = OV_SHOWN;
                end
            end
            default: state_d = OV_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            OV_SHOWN, OV_HELD: ovf_n_o = 1'b0;
            default:           ovf_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
    import bcdc_pkg::*;
#(
    parameter int NUM_DECADES = 8
) (
    input  logic                           clk,
    input  logic                           trig_i,
    input  logic                           cnt_rst_n,
    input  logic                           disp_n,
    output logic [NUM_DECADES*DIGIT_W-1:0] digits_o,
    output logic                           ovf_n
);

    localparam int BUS_W = NUM_DECADES * DIGIT_W;

    logic                   trig_fall;
    logic [NUM_DECADES:0]   stage_en;
    logic [BUS_W-1:0]       digit_bus;

    bcdc_fall_detect u_fall (
        .clk    (clk),
        .sig_i  (trig_i),
        .fall_o (trig_fall)
    );

    assign stage_en[0] = trig_fall;

    for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
        bcdc_decade u_dec (
            .clk     (clk),
            .clr_n_i (cnt_rst_n),
            .en_i    (stage_en[g]),
            .digit_o (digit_bus[g*DIGIT_W +: DIGIT_W]),
            .carry_o (stage_en[g+1])
        );
    end

    bcdc_ovf_fsm u_ovf (
        .clk        (clk),
        .clr_n_i    (cnt_rst_n),
        .full_i     (stage_en[NUM_DECADES]),
        .strobe_n_i (disp_n),
        .ovf_n_o    (ovf_n)
    );

    assign digits_o = digit_bus;

endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker #(
    parameter int NUM_DECADES = 8
) (
    input logic                     clk,
    input logic                     trig_i,
    input logic                     cnt_rst_n,
    input logic                     disp_n,
    input logic [NUM_DECADES*4-1:0] digits_o,
    input logic                     ovf_n
);

    // R4: no digit ever leaves 0..9
    always @(posedge clk) begin
        if (cnt_rst_n) begin
            for (int i = 0; i < NUM_DECADES; i++) begin
                p_digit_bcd_r4: assert (digits_o[4*i +: 4] <= 4'd9)
                    else $error("digit %0d out of BCD range", i);
            end
        end
    end

    // R3: reset zeroes the count
    p_reset_zero_r3: assert property (@(posedge clk)
        !cnt_rst_n |=> (digits_o == '0));

    // R1: no fall of the trigger, no change of the count
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!cnt_rst_n)
        (trig_i || !$past(trig_i)) |=> $stable(digits_o));

    // R7: the overflow pin only falls after a strobe
    p_ovf_strobe_r7: assert property (@(posedge clk) disable iff (!cnt_rst_n)
        $fell(ovf_n) |-> $past(!disp_n));

    // R8: asserted overflow holds while no reset is taken
    p_ovf_hold_r8: assert property (@(posedge clk)
        (cnt_rst_n && !ovf_n) |=> !ovf_n);

    // R8: reset under a high strobe releases the pin
    p_ovf_release_r8: assert property (@(posedge clk)
        (!cnt_rst_n && disp_n) |=> ovf_n);

endmodule

bind bcd_event_counter bcdc_checker #(.NUM_DECADES(NUM_DECADES)) u_chk (
    .clk       (clk),
    .trig_i    (trig_i),
    .cnt_rst_n (cnt_rst_n),
    .disp_n    (disp_n),
    .digits_o  (digits_o),
    .ovf_n     (ovf_n)
);

// File: tb/bcd_event_counter_tb.sv
module bcd_event_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ND         = 3;
    localparam int WRAP       = 1000;   // 10**ND
    localparam int WATCHDOG   = 40000;

    logic          clk = 1'b0;
    logic          trig_i = 1'b1;
    logic          cnt_rst_n = 1'b0;
    logic          disp_n = 1'b1;
    logic [ND*4-1:0] digits_o;
    logic          ovf_n;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    started  = 0;
    bit    done     = 0;
    string tag      = "R3";

    // behavioural reference state
    int m_count  = 0;
    bit m_flag   = 0;
    bit m_shown  = 0;
    bit m_prev   = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_event_counter #(.NUM_DECADES(ND)) u_dut (
        .clk       (clk),
        .trig_i    (trig_i),
        .cnt_rst_n (cnt_rst_n),
        .disp_n    (disp_n),
        .digits_o  (digits_o),
        .ovf_n     (ovf_n)
    );

    function automatic logic [ND*4-1:0] to_bcd(int v);
        logic [ND*4-1:0] r;
        int x = v;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference update on each rising edge
    always @(posedge clk) begin
        bit fall;
        bit old_flag;
        fall     = m_prev && !trig_i;
        m_prev   = trig_i;
        old_flag = m_flag;
        if (!cnt_rst_n) begin
            m_count = 0;
            m_flag  = 0;
            if (disp_n) m_shown = 0;
        end else begin
            if (!disp_n && old_flag) m_shown = 1;
            if (fall) begin
                if (m_count == WRAP - 1) m_flag = 1;
                m_count = (m_count + 1) % WRAP;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(tag, "digits", int'(digits_o), int'(to_bcd(m_count)));
            check(tag, "ovf_n", int'(ovf_n), int'(!m_shown));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int lo, int hi);
        trig_i = 1'b0;
        cyc(lo);
        trig_i = 1'b1;
        cyc(hi);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        cyc(3);
        started = 1;
        tag = "R3";
        cyc(1);
        check("R3", "reset digits", int'(digits_o), 0);
        cnt_rst_n = 1'b1;
        cyc(1);

        // R1: various pulse widths, steady levels
        tag = "R1";
        pulse(1, 1);
        pulse(1, 3);
        pulse(4, 1);
        pulse(2, 5);
        check("R1", "four events", int'(digits_o), 12'h004);

        // R2: count visible one edge after the low is driven
        tag = "R2";
        trig_i = 1'b0;
        cyc(1);
        check("R2", "next-edge count", int'(digits_o), 12'h005);
        trig_i = 1'b1;
        cyc(1);

        // R4: carries through 9->10 and 99->100
        tag = "R4";
        for (int i = 0; i < 118; i++) pulse(1, 1);
        tag = "R5";
        check("R5", "digit layout 123", int'(digits_o), 12'h123);

        // R3: reset beats a simultaneous fall
        tag = "R3";
        trig_i = 1'b0;
        cnt_rst_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b1;
        check("R3", "reset priority", int'(digits_o), 0);
        trig_i = 1'b1;
        cyc(1);

        // R6: roll over the maximum
        tag = "R6";
        for (int i = 0; i < WRAP - 1; i++) pulse(1, 1);
        check("R6", "all nines", int'(digits_o), 12'h999);
        tag = "R7";
        pulse(1, 1);
        check("R6", "wrap to zero", int'(digits_o), 0);
        cyc(2);
        check("R7", "no strobe no overflow", int'(ovf_n), 1);

        // R7: strobe shows overflow
        disp_n = 1'b0;
        cyc(1);
        check("R7", "strobe asserts", int'(ovf_n), 0);
        disp_n = 1'b1;
        cyc(1);

        // R8: held through counts and strobes, released by reset
        tag = "R8";
        for (int i = 0; i < 5; i++) pulse(1, 1);
        disp_n = 1'b0; cyc(2); disp_n = 1'b1; cyc(2);
        check("R8", "held low", int'(ovf_n), 0);
        cnt_rst_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b1;
        check("R8", "released", int'(ovf_n), 1);
        cyc(2);

        // R9: reset under low strobe keeps the pin low
        tag = "R9";
        for (int i = 0; i < WRAP; i++) pulse(1, 1);
        disp_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b1;
        check("R9", "held after reset", int'(ovf_n), 0);
        disp_n = 1'b1;
        cyc(3);
        check("R9", "still held", int'(ovf_n), 0);
        cnt_rst_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b1;
        check("R9", "released later", int'(ovf_n), 1);
        cyc(2);

        // R10: reset wins over a strobe on a pending flag
        tag = "R10";
        for (int i = 0; i < WRAP; i++) pulse(1, 1);
        disp_n = 1'b0;
        cnt_rst_n = 1'b0;
        cyc(1);
        cnt_rst_n = 1'b1;
        check("R10", "reset wins", int'(ovf_n), 1);
        cyc(3);
        check("R10", "flag gone", int'(ovf_n), 1);
        disp_n = 1'b1;
        cyc(2);

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule